// File: doc/BRIEF.md
# Serial Link Training Controller with Forced State Entry

This block sequences the bring-up of a serial link. After reset it sits in a quiet detect phase. It then makes one receiver-sense attempt, and if a far end is reported it moves through two polling steps and a configuration step into the operating state, where it raises a link-up flag. The physical layer is abstract. The block asks for a detect pulse and reads back a single receiver-present flag. The link partner is represented by two flags: a handshake seen during polling that must also hold while the link is up, and a configuration-complete flag.

Some media cannot be sensed electrically, so the detect attempt fails on every retry. For that case a one-cycle force strobe with a target-state code moves the machine straight into a detect or polling state, and training then carries on from there. A force that names the configuration or operating state would skip negotiation with the partner. Such a request is refused, and a sticky error flag records it.

Top module: `link_train_ctrl`

## Requirements
- R1: While `rst_ni` is low the state code is 0x00 (detect quiet), and `link_up_o`, `det_pulse_o` and `force_err_o` are 0. Reset acts asynchronously.
- R2: Detect quiet lasts exactly QUIET_CYC cycles and is then followed by detect active (code 0x01).
- R3: Detect active lasts one cycle, and `det_pulse_o` is high in that cycle only. If `rx_det_i` is 1 in that cycle the next state is polling active (0x02). Otherwise the next state is detect quiet, and the attempt repeats without limit.
- R4: Polling active moves to polling configuration (0x03) in the cycle after `poll_ok_i` has been high for POLL_CNT consecutive cycles. A low cycle restarts the run.
- R5: Polling configuration moves to configuration (0x04) after one cycle.
- R6: Configuration moves to the operating state (0x10) in the cycle after `cfg_done_i` is high, and waits there otherwise.
- R7: `link_up_o` is 1 only in the operating state. A low `poll_ok_i` in that state returns the machine to detect quiet.
- R8: A `force_i` pulse whose `force_state_i` is 0x00, 0x01, 0x02 or 0x03 makes that code the next state. This takes priority over every normal transition in the same cycle. Training then continues normally from that state.
- R9: A `force_i` pulse with any other code has no effect on the state and sets `force_err_o`. The flag stays set until `start_i` is asserted.
- R10: `start_i` sends the machine to detect quiet, clears `force_err_o`, and overrides a force in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous restart of training |
| rx_det_i | input | 1 | Receiver present, from the PHY |
| poll_ok_i | input | 1 | Partner handshake during polling and while the link is up |
| cfg_done_i | input | 1 | Partner configuration complete |
| force_i | input | 1 | One-cycle force strobe |
| force_state_i | input | 5 | Target state code for the force |
| det_pulse_o | output | 1 | Detect pulse request to the PHY |
| state_o | output | 5 | Current state code |
| link_up_o | output | 1 | Link is in the operating state |
| force_err_o | output | 1 | Sticky flag for a refused force |

## Verification
On every cycle the assertions check the following: the length of detect quiet measured against an independent run counter, the single-cycle detect pulse, the landing state after an accepted force, the setting and holding of the refusal flag, restart, the exit from the operating state on handshake loss, and the entry into the link-up state from configuration. Other behaviour can only be shown by the bench scenarios. These are the exact consecutive-handshake count in polling and its restart when a run is broken, the endless detect retry loop, and force priority when a normal transition is pending in the same cycle. The scenarios also cover force targets that are refused while training continues, and asynchronous reset from the operating state.

// File: rtl/link_train_pkg.sv
package link_train_pkg;
  localparam int STATE_W = 5;

  typedef enum logic [STATE_W-1:0] {
    ST_DET_QUIET  = 5'h00,
    ST_DET_ACTIVE = 5'h01,
    ST_POLL_ACT   = 5'h02,
    ST_POLL_CFG   = 5'h03,
    ST_CONFIG     = 5'h04,
    ST_LINK_UP    = 5'h10
  } lt_state_e;

  // Only detect and polling codes may be forced; later states need partner negotiation.
  function automatic logic force_code_ok(input logic [STATE_W-1:0] code);
    return (code == ST_DET_QUIET) || (code == ST_DET_ACTIVE) ||
           (code == ST_POLL_ACT)  || (code == ST_POLL_CFG);
  endfunction
endpackage

// File: rtl/lt_run_counter.sv
module lt_run_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i || !en_i || hit_o)    cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lt_force_decode.sv
module lt_force_decode
  import link_train_pkg::*;
(
  input  logic               force_i,
  input  logic [STATE_W-1:0] force_state_i,
  output logic               take_o,
  output logic               reject_o,
  output lt_state_e          target_o
);
  logic code_ok;

  always_comb begin
    code_ok  = force_code_ok(force_state_i);
    take_o   = force_i && code_ok;
    reject_o = force_i && !code_ok;
    target_o = code_ok ? lt_state_e'(force_state_i) : ST_DET_QUIET;
  end
endmodule

// File: rtl/lt_state_core.sv
module lt_state_core
  import link_train_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      rx_det_i,
  input  logic      poll_ok_i,
  input  logic      cfg_done_i,
  input  logic      take_i,
  input  logic      reject_i,
  input  lt_state_e target_i,
  input  logic      quiet_hit_i,
  input  logic      poll_hit_i,
  output lt_state_e state_o,
  output logic      err_o
);
  lt_state_e state_q, state_d;
  logic      err_q;

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_DET_QUIET;
    end else if (take_i) begin
      state_d = target_i;
    end else begin
      unique case (state_q)
        ST_DET_QUIET:  if (quiet_hit_i) state_d = ST_DET_ACTIVE;
        ST_DET_ACTIVE: state_d = rx_det_i ? ST_POLL_ACT : ST_DET_QUIET;
        ST_POLL_ACT:   if (poll_hit_i) state_d = ST_POLL_CFG;
        ST_POLL_CFG:   state_d = ST_CONFIG;
        ST_CONFIG:     if (cfg_done_i) state_d = ST_LINK_UP;
        ST_LINK_UP:    if (!poll_ok_i) state_d = ST_DET_QUIET;
        default:       state_d = ST_DET_QUIET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DET_QUIET;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i)       err_q <= 1'b0;
      else if (reject_i) err_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
  import link_train_pkg::*;
#(
  parameter int QUIET_CYC = 16,
  parameter int POLL_CNT  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               rx_det_i,
  input  logic               poll_ok_i,
  input  logic               cfg_done_i,
  input  logic               force_i,
  input  logic [STATE_W-1:0] force_state_i,
  output logic               det_pulse_o,
  output logic [STATE_W-1:0] state_o,
  output logic               link_up_o,
  output logic               force_err_o
);
  lt_state_e state;
  lt_state_e target;
  logic      take, reject, restart;
  logic      quiet_hit, poll_hit;

  assign restart = start_i || take;

  lt_force_decode u_force (
    .force_i       (force_i),
    .force_state_i (force_state_i),
    .take_o        (take),
    .reject_o      (reject),
    .target_o      (target)
  );

  lt_run_counter #(.LIMIT(QUIET_CYC)) u_quiet (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .en_i   (state == ST_DET_QUIET),
    .hit_o  (quiet_hit)
  );

  lt_run_counter #(.LIMIT(POLL_CNT)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .en_i   ((state == ST_POLL_ACT) && poll_ok_i),
    .hit_o  (poll_hit)
  );

  lt_state_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rx_det_i    (rx_det_i),
    .poll_ok_i   (poll_ok_i),
    .cfg_done_i  (cfg_done_i),
    .take_i      (take),
    .reject_i    (reject),
    .target_i    (target),
    .quiet_hit_i (quiet_hit),
    .poll_hit_i  (poll_hit),
    .state_o     (state),
    .err_o       (force_err_o)
  );

  assign state_o     = state;
  assign det_pulse_o = (state == ST_DET_ACTIVE);
  assign link_up_o   = (state == ST_LINK_UP);
endmodule

// File: rtl/link_train_ctrl_checker.sv
module link_train_ctrl_checker
  import link_train_pkg::*;
#(
  parameter int QUIET_CYC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               poll_ok_i,
  input logic               cfg_done_i,
  input logic               force_i,
  input logic [STATE_W-1:0] force_state_i,
  input logic               det_pulse_o,
  input logic [STATE_W-1:0] state_o,
  input logic               link_up_o,
  input logic               force_err_o
);
  logic        frc_ok;
  logic [31:0] quiet_run;

  assign frc_ok = force_i && (force_state_i <= 5'h03);

  // independent count of cycles spent in detect quiet since its last entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          quiet_run <= 32'd0;
    else if (start_i || frc_ok)           quiet_run <= 32'd0;
    else if (state_o == ST_DET_QUIET)     quiet_run <= quiet_run + 32'd1;
    else                                  quiet_run <= 32'd0;
  end

  assert_quiet_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DET_ACTIVE && $past(state_o) == ST_DET_QUIET && !$past(force_i) && !$past(start_i))
      |-> quiet_run == QUIET_CYC);

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_pulse_o && !force_i) |=> !det_pulse_o);

  assert_force_land_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_ok && !start_i) |=> state_o == $past(force_state_i));

  assert_force_refuse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !frc_ok && !start_i) |=> force_err_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_err_o && !start_i) |=> force_err_o);

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_o == ST_DET_QUIET && !force_err_o));

  assert_link_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_up_o && !poll_ok_i && !start_i && !force_i) |=> state_o == ST_DET_QUIET);

  assert_link_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_o) |-> ($past(state_o) == ST_CONFIG && $past(cfg_done_i)));
endmodule

bind link_train_ctrl link_train_ctrl_checker #(.QUIET_CYC(QUIET_CYC)) u_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .poll_ok_i     (poll_ok_i),
  .cfg_done_i    (cfg_done_i),
  .force_i       (force_i),
  .force_state_i (force_state_i),
  .det_pulse_o   (det_pulse_o),
  .state_o       (state_o),
  .link_up_o     (link_up_o),
  .force_err_o   (force_err_o)
);

// File: tb/link_train_ctrl_test.sv
module link_train_ctrl_test;
  localparam int QUIET = 4;
  localparam int PCNT  = 3;
  localparam int NV    = 32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, rx_det_i = 1'b0, poll_ok_i = 1'b0, cfg_done_i = 1'b0, force_i = 1'b0;
  logic [4:0] force_state_i = 5'h00;
  logic       det_pulse_o, link_up_o, force_err_o;
  logic [4:0] state_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  link_train_ctrl #(.QUIET_CYC(QUIET), .POLL_CNT(PCNT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rx_det_i(rx_det_i),
    .poll_ok_i(poll_ok_i), .cfg_done_i(cfg_done_i), .force_i(force_i),
    .force_state_i(force_state_i), .det_pulse_o(det_pulse_o), .state_o(state_o),
    .link_up_o(link_up_o), .force_err_o(force_err_o)
  );

  // req, start, rx_det, poll_ok, cfg_done, force, force code, exp state, exp det, exp up, exp err
  typedef struct packed {
    logic [3:0] req;
    logic       st, rx, pok, cd, frc;
    logic [4:0] fcode;
    logic [4:0] est;
    logic       edet, eup, eerr;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0}, // R2 quiet
    '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0},
    '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0},
    '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h01,1'b1,1'b0,1'b0}, // R3 pulse
    '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0}, // R3 retry
    '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0},
    '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0},
    '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0},
    '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h01,1'b1,1'b0,1'b0},
    '{4'd3,  1'b0,1'b1,1'b0,1'b0,1'b0,5'h00, 5'h02,1'b0,1'b0,1'b0}, // R3 found
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h02,1'b0,1'b0,1'b0}, // R4 run
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h02,1'b0,1'b0,1'b0},
    '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h02,1'b0,1'b0,1'b0}, // R4 broken
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h02,1'b0,1'b0,1'b0},
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h02,1'b0,1'b0,1'b0},
    '{4'd4,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h03,1'b0,1'b0,1'b0},
    '{4'd5,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h04,1'b0,1'b0,1'b0}, // R5
    '{4'd6,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h04,1'b0,1'b0,1'b0}, // R6 wait
    '{4'd6,  1'b0,1'b0,1'b1,1'b1,1'b0,5'h00, 5'h10,1'b0,1'b1,1'b0}, // R6 up
    '{4'd7,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h10,1'b0,1'b1,1'b0}, // R7 hold
    '{4'd7,  1'b0,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0}, // R7 drop
    '{4'd8,  1'b0,1'b0,1'b0,1'b0,1'b1,5'h02, 5'h02,1'b0,1'b0,1'b0}, // R8 skip detect
    '{4'd9,  1'b0,1'b0,1'b0,1'b0,1'b1,5'h10, 5'h02,1'b0,1'b0,1'b1}, // R9 refuse L0
    '{4'd9,  1'b0,1'b0,1'b0,1'b0,1'b1,5'h04, 5'h02,1'b0,1'b0,1'b1}, // R9 refuse config
    '{4'd10, 1'b1,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0}, // R10 restart
    '{4'd8,  1'b0,1'b0,1'b0,1'b0,1'b1,5'h01, 5'h01,1'b1,1'b0,1'b0},
    '{4'd8,  1'b0,1'b1,1'b0,1'b0,1'b1,5'h00, 5'h00,1'b0,1'b0,1'b0}, // R8 priority
    '{4'd8,  1'b0,1'b0,1'b0,1'b0,1'b1,5'h03, 5'h03,1'b0,1'b0,1'b0},
    '{4'd8,  1'b0,1'b0,1'b1,1'b0,1'b0,5'h00, 5'h04,1'b0,1'b0,1'b0}, // R8 continues
    '{4'd10, 1'b1,1'b0,1'b0,1'b0,1'b1,5'h02, 5'h00,1'b0,1'b0,1'b0}, // R10 beats force
    '{4'd9,  1'b0,1'b0,1'b0,1'b0,1'b1,5'h07, 5'h00,1'b0,1'b0,1'b1}, // R9 unknown code
    '{4'd10, 1'b1,1'b0,1'b0,1'b0,1'b0,5'h00, 5'h00,1'b0,1'b0,1'b0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    start_i = v.st; rx_det_i = v.rx; poll_ok_i = v.pok; cfg_done_i = v.cd;
    force_i = v.frc; force_state_i = v.fcode;
  endtask

  initial begin
    #25;
    // R1 reset values
    check("R1", "state", state_o, 5'h00);
    check("R1", "link_up", link_up_o, 0);
    check("R1", "det_pulse", det_pulse_o, 0);
    check("R1", "force_err", force_err_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d v%0d", VECS[i].req, i);
      drive(VECS[i]);
      @(negedge clk);
      check(tag, "state", state_o, VECS[i].est);
      check(tag, "det_pulse", det_pulse_o, VECS[i].edet);
      check(tag, "link_up", link_up_o, VECS[i].eup);
      check(tag, "force_err", force_err_o, VECS[i].eerr);
    end

    // R8 forced polling, then R4..R6 to the operating state; R1 async reset from there
    drive('0);
    force_i = 1'b1; force_state_i = 5'h02;
    @(negedge clk);
    force_i = 1'b0; poll_ok_i = 1'b1;
    repeat (PCNT) @(negedge clk);
    check("R4", "state after run", state_o, 5'h03);
    @(negedge clk);
    cfg_done_i = 1'b1;
    @(negedge clk);
    check("R6", "state", state_o, 5'h10);
    check("R7", "link_up", link_up_o, 1);
    #5 rst_ni = 1'b0;
    #1;
    check("R1", "async state", state_o, 5'h00);
    check("R1", "async link_up", link_up_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive('0);

    // R3 endless retry: no receiver for several attempts never reaches polling
    for (int k = 0; k < 4 * (QUIET + 1); k++) begin
      @(negedge clk);
      if (state_o == 5'h02) check("R3", "left detect without receiver", state_o, 5'h00);
    end
    check("R3", "still in detect", int'(state_o <= 5'h01), 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule